// File: doc/BRIEF.md
# Per-CPU Interrupt Level Combiner

This block sits beside one processor and decides which of its fifteen interrupt request levels are raised. It keeps a 32-bit pending word. The upper fifteen bits hold software interrupts that the processor raises and lowers through a small register window. Two more bits track the processor's private timer line and a level-15 broadcast line that every processor receives. The block ORs these with the hardware level vector that the system router steers to this processor. The result is a level vector plus a 4-bit number for the highest raised level.

The register window is four 32-bit words. Word 0 reads the pending word, word 1 clears bits and word 2 sets bits. A master-disable flag blocks the router levels and the timer and level-15 contributions, but not the software levels. While the target-select flag marks this processor as the router's target, the router levels also show up in the readable pending word.

All inputs and bus writes are sampled on the rising clock edge. The new pending word, level vector and highest level are visible right after that edge.

Top module: `pcic_combiner`

## Requirements
- R1: After reset, the pending word reads 0x00000000, `irq_vec` is 0 and `irq_top` is 0.
- R2: Word index 0 (`acc_word`=0) returns the pending word on `acc_rdata`. Word indices 1, 2 and 3 return zero.
- R3: A write to word 2 ORs `acc_wdata & 0xFFFE0000` into the pending word. Bits 16 down to 0 of that write have no effect.
- R4: A write to word 1 clears the pending bits selected by `acc_wdata & 0xFFFE8000`, so only soft bits and bit 15 can be cleared. Bit 14 is not affected. Writes to words 0 and 3 change nothing.
- R5: Pending soft bit n (17..31) raises level n-16 of `irq_vec`, whatever the state of `master_off`.
- R6: Pending bit 14 equals `timer_in` from the last edge. Pending bit 15 is set when `lvl15_in` rises and cleared when it falls. Bits 14 and 15 raise levels 14 and 15 only while `master_off` is 0.
- R7: While `is_target` is 1, `hw_levels[15:1]` is ORed into pending bits 15..1, and these levels reach `irq_vec` when `master_off` is 0. While `is_target` is 0, these mirrored bits read as zero and the router contributes no level.
- R8: `irq_vec[0]` is always 0. `irq_top` is the index of the highest set bit of `irq_vec`, or 0 when no bit is set.
- R9: A bus write and an input change in the same cycle both take effect. A rising `lvl15_in` sets bit 15 even if a clear of bit 15 is written in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Bus access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_word | input | 2 | Word index in the 16-byte window |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data for `acc_word` |
| timer_in | input | 1 | Per-processor timer request |
| lvl15_in | input | 1 | Level-15 broadcast request |
| master_off | input | 1 | Master disable |
| is_target | input | 1 | This processor is the router target |
| hw_levels | input | 16 | Router level vector, bit n = level n |
| irq_vec | output | 16 | Request level vector, bit n = level n |
| irq_top | output | 4 | Highest requested level |

## Verification
Two things can land on the same edge: a bus write to the set or clear word, and a change on the timer, level-15, target or router inputs. The bench provokes this by driving a write together with an input change in one cycle. One case is a clear of bit 15 written while `lvl15_in` rises. Another is a soft set written while a router level and the target flag change. After the edge it reads the pending word and the level vector. Both effects must be present: the written soft bits, and the new bits 14, 15 and mirrored levels.

// File: rtl/pcic_pkg.sv
package pcic_pkg;
    localparam int DATA_W   = 32;
    localparam int NLEV     = 16;
    localparam int SOFT_W   = NLEV - 1;
    localparam int TOP_W    = $clog2(NLEV);
    localparam int BIT_L15  = 15;
    localparam int BIT_TMR  = 14;
    localparam logic [DATA_W-1:0] SET_MASK = 32'hFFFE_0000;
    localparam logic [DATA_W-1:0] CLR_MASK = 32'hFFFE_8000;

    typedef enum logic [1:0] {
        W_PEND  = 2'd0,
        W_CLR   = 2'd1,
        W_SET   = 2'd2,
        W_SPARE = 2'd3
    } word_e;
endpackage

// File: rtl/pcic_soft_reg.sv
module pcic_soft_reg
    import pcic_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_set,
    input  logic              wr_clr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              timer_in,
    input  logic              lvl15_in,
    output logic [SOFT_W-1:0] soft_q,
    output logic              l15_q,
    output logic              tmr_q
);
    logic              l15_prev;
    logic [SOFT_W-1:0] set_bits, clr_bits;
    logic              rise, fall, wclr15;

    always_comb begin
        set_bits = wr_set ? (wdata & SET_MASK) >> (DATA_W - SOFT_W) : '0;
        clr_bits = wr_clr ? (wdata & CLR_MASK) >> (DATA_W - SOFT_W) : '0;
        rise     = lvl15_in & ~l15_prev;
        fall     = ~lvl15_in & l15_prev;
        wclr15   = wr_clr & wdata[BIT_L15];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            soft_q   <= '0;
            l15_q    <= 1'b0;
            l15_prev <= 1'b0;
            tmr_q    <= 1'b0;
        end else begin
            soft_q   <= (soft_q | set_bits) & ~clr_bits;
            l15_prev <= lvl15_in;
            tmr_q    <= timer_in;
            if (rise)        l15_q <= 1'b1;
            else if (fall)   l15_q <= 1'b0;
            else if (wclr15) l15_q <= 1'b0;
        end
    end

    a_r3_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> ((soft_q & $past(set_bits)) == $past(set_bits)));
    a_r6_timer_follows: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (tmr_q == $past(timer_in)));
    a_r9_rise_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl15_in && !l15_prev) |=> l15_q);
endmodule

// File: rtl/pcic_hw_mirror.sv
module pcic_hw_mirror
    import pcic_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NLEV-1:0] hw_levels,
    input  logic            is_target,
    input  logic            master_off,
    output logic [NLEV-1:0] mir_q,
    output logic            off_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mir_q <= '0;
            off_q <= 1'b0;
        end else begin
            mir_q <= is_target ? {hw_levels[NLEV-1:1], 1'b0} : '0;
            off_q <= master_off;
        end
    end

    a_r7_no_target_no_mirror: assert property (@(posedge clk) disable iff (!rst_n)
        !is_target |=> (mir_q == '0));
endmodule

// File: rtl/pcic_level_merge.sv
module pcic_level_merge
    import pcic_pkg::*;
(
    input  logic [SOFT_W-1:0] soft_q,
    input  logic              l15_q,
    input  logic              tmr_q,
    input  logic [NLEV-1:0]   mir_q,
    input  logic              off_q,
    output logic [NLEV-1:0]   vec,
    output logic [TOP_W-1:0]  top
);
    assign vec[0] = 1'b0;

    for (genvar g = 1; g < NLEV; g++) begin : g_lvl
        logic side;
        if (g == BIT_L15)      begin : g_l15 assign side = l15_q; end
        else if (g == BIT_TMR) begin : g_tmr assign side = tmr_q; end
        else                   begin : g_no  assign side = 1'b0;  end
        assign vec[g] = soft_q[g-1] | (~off_q & (mir_q[g] | side));
    end

    always_comb begin
        top = '0;
        for (int i = 1; i < NLEV; i++) begin
            if (vec[i]) top = i[TOP_W-1:0];
        end
    end
endmodule

// File: rtl/pcic_combiner.sv
module pcic_combiner
    import pcic_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        acc_valid,
    input  logic        acc_write,
    input  logic [1:0]  acc_word,
    input  logic [31:0] acc_wdata,
    output logic [31:0] acc_rdata,
    input  logic        timer_in,
    input  logic        lvl15_in,
    input  logic        master_off,
    input  logic        is_target,
    input  logic [15:0] hw_levels,
    output logic [15:0] irq_vec,
    output logic [3:0]  irq_top
);
    logic [SOFT_W-1:0] soft_q;
    logic              l15_q, tmr_q, off_q;
    logic [NLEV-1:0]   mir_q;
    logic [DATA_W-1:0] pend;
    logic              wr_set, wr_clr;
    word_e             wsel;

    assign wsel   = word_e'(acc_word);
    assign wr_set = acc_valid & acc_write & (wsel == W_SET);
    assign wr_clr = acc_valid & acc_write & (wsel == W_CLR);

    pcic_soft_reg u_soft (
        .clk(clk), .rst_n(rst_n), .wr_set(wr_set), .wr_clr(wr_clr),
        .wdata(acc_wdata), .timer_in(timer_in), .lvl15_in(lvl15_in),
        .soft_q(soft_q), .l15_q(l15_q), .tmr_q(tmr_q)
    );

    pcic_hw_mirror u_mir (
        .clk(clk), .rst_n(rst_n), .hw_levels(hw_levels), .is_target(is_target),
        .master_off(master_off), .mir_q(mir_q), .off_q(off_q)
    );

    pcic_level_merge u_merge (
        .soft_q(soft_q), .l15_q(l15_q), .tmr_q(tmr_q), .mir_q(mir_q),
        .off_q(off_q), .vec(irq_vec), .top(irq_top)
    );

    assign pend = {soft_q, 1'b0, l15_q | mir_q[BIT_L15], tmr_q | mir_q[BIT_TMR],
                   mir_q[BIT_TMR-1:0]};

    always_comb begin
        unique case (wsel)
            W_PEND:  acc_rdata = pend;
            W_CLR,
            W_SET,
            W_SPARE: acc_rdata = '0;
        endcase
    end

    a_r8_level0_zero: assert property (@(posedge clk) disable iff (!rst_n)
        irq_vec[0] == 1'b0);
    a_r8_top_is_set: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_vec != '0) |-> irq_vec[irq_top]);
    a_r6_off_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        off_q |-> ((irq_vec[NLEV-1:1] & ~soft_q) == '0));
    a_r3_bit16_zero: assert property (@(posedge clk) disable iff (!rst_n)
        pend[16] == 1'b0 && pend[0] == 1'b0);
endmodule

// File: tb/pcic_combiner_tb.sv
`timescale 1ns/1ps
module pcic_combiner_tb;
    logic        clk = 0, rst_n = 0;
    logic        acc_valid = 0, acc_write = 0;
    logic [1:0]  acc_word = 0;
    logic [31:0] acc_wdata = 0, acc_rdata;
    logic        timer_in = 0, lvl15_in = 0, master_off = 0, is_target = 0;
    logic [15:0] hw_levels = 0, irq_vec;
    logic [3:0]  irq_top;

    int checks = 0, failures = 0;
    logic [31:0] m_soft = 0;
    logic        m_l15 = 0, m_prev = 0, m_tmr = 0, m_off = 0;
    logic [15:0] m_mir = 0;

    always #2 clk = ~clk;

    pcic_combiner u_dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_word(acc_word), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .timer_in(timer_in), .lvl15_in(lvl15_in), .master_off(master_off),
        .is_target(is_target), .hw_levels(hw_levels), .irq_vec(irq_vec),
        .irq_top(irq_top)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_pend();
        return m_soft | {16'h0, m_l15, m_tmr, 14'h0} | {16'h0, m_mir};
    endfunction

    function automatic logic [15:0] exp_vec();
        logic [15:0] v;
        v = m_soft[31:16];
        if (!m_off) v = v | m_mir | {m_l15, m_tmr, 14'h0};
        v[0] = 1'b0;
        return v;
    endfunction

    function automatic logic [3:0] exp_top(logic [15:0] v);
        logic [3:0] t = 0;
        for (int i = 1; i < 16; i++) if (v[i]) t = 4'(i);
        return t;
    endfunction

    task automatic check_all(string tag);
        logic [15:0] v;
        v = exp_vec();
        chk({tag, " pending"}, acc_rdata, exp_pend());
        chk({tag, " vec"}, {16'h0, irq_vec}, {16'h0, v});
        chk({tag, " top"}, {28'h0, irq_top}, {28'h0, exp_top(v)});
    endtask

    // One edge: inputs already set; optional write; then model update and check.
    task automatic step(string tag, bit wr, logic [1:0] w, logic [31:0] d);
        acc_valid = wr; acc_write = wr; acc_word = w; acc_wdata = d;
        @(posedge clk);
        if (wr && w == 2) m_soft = m_soft | (d & 32'hFFFE_0000);
        if (wr && w == 1) m_soft = m_soft & ~(d & 32'hFFFE_0000);
        if (lvl15_in && !m_prev) m_l15 = 1;
        else if (!lvl15_in && m_prev) m_l15 = 0;
        else if (wr && w == 1 && d[15]) m_l15 = 0;
        m_prev = lvl15_in;
        m_tmr  = timer_in;
        m_mir  = is_target ? (hw_levels & 16'hFFFE) : 16'h0;
        m_off  = master_off;
        #1;
        acc_valid = 0; acc_write = 0; acc_word = 0; acc_wdata = 0;
        #0.5;
        check_all(tag);
        @(negedge clk);
    endtask

    initial begin
        #(4 * 100000);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #9;
        check_all("R1 reset");
        rst_n = 1;
        @(negedge clk);
        step("R1 idle", 0, 0, 0);

        // R5/R3/R4: every soft bit alone, set then clear, master off toggled
        for (int n = 17; n < 32; n++) begin
            master_off = n[0];
            step("R5 R3 set one", 1, 2, 32'h1 << n);
            step("R4 clear one", 1, 1, 32'h1 << n);
        end
        master_off = 0;
        step("R3 set all masked", 1, 2, 32'hFFFF_FFFF);
        // R2: other words read zero
        for (int w = 1; w < 4; w++) begin
            acc_word = 2'(w); #0.5;
            chk("R2 other word", acc_rdata, 32'h0);
            acc_word = 0;
        end
        step("R4 word0 write ignored", 1, 0, 32'hFFFF_FFFF);
        step("R4 word3 write ignored", 1, 3, 32'hFFFF_FFFF);
        step("R4 clear pattern", 1, 1, 32'hA5A5_0000);
        step("R4 clear rest", 1, 1, 32'hFFFF_FFFF);

        // R6: timer / level-15 / master_off sweep
        for (int k = 0; k < 8; k++) begin
            timer_in = k[0]; lvl15_in = k[1]; master_off = k[2];
            step("R6 sweep", 0, 0, 0);
        end
        timer_in = 1; lvl15_in = 0; master_off = 0;
        step("R6 fall", 0, 0, 0);
        lvl15_in = 1;
        step("R6 rise", 0, 0, 0);
        step("R4 clear bit15 keeps bit14", 1, 1, 32'h0000_FFFF);
        step("R6 level held no reset", 0, 0, 0);
        lvl15_in = 0; timer_in = 0;
        step("R6 release", 0, 0, 0);

        // R7/R8: router levels one-hot x target x off
        for (int t = 0; t < 2; t++)
            for (int o = 0; o < 2; o++)
                for (int l = 0; l < 16; l++) begin
                    is_target = t[0]; master_off = o[0];
                    hw_levels = 16'h1 << l;
                    step("R7 R8 hw level", 0, 0, 0);
                end
        is_target = 1; master_off = 0; hw_levels = 16'h0124;
        step("R8 multi level", 1, 2, 32'h0008_0000);
        hw_levels = 0;
        step("R7 drop", 1, 1, 32'hFFFF_0000);

        // R9: simultaneous write and input change
        lvl15_in = 1;
        step("R9 rise vs clear", 1, 1, 32'h0000_8000);
        lvl15_in = 0; hw_levels = 16'h0402; timer_in = 1;
        step("R9 set with hw change", 1, 2, 32'h4002_0000);
        is_target = 0; master_off = 1; timer_in = 0;
        step("R9 clear with target drop", 1, 1, 32'h4000_0000);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule